// File: doc/BRIEF.md
# Dual 8-bit Timer with Shared Control/Status Byte

The block holds two independent up-counters, a high half and a low half. Each half has its own compare register and its own count-enable tick input. One control/status byte serves both halves. For each half it packs an overflow flag, a compare-match flag, an overflow interrupt enable and a counter-clear select. Software uses a simple synchronous register bus to read and write this byte, both counters and both compare registers.

The hardware sets the status flags, and software cannot set them. To clear a flag, software must first read the byte and see that flag as 1, and then write 0 to that bit. A flag that has not been read as 1 ignores a written 0. If the hardware sets a flag in the same cycle that software clears it, the flag stays set. Each half drives an overflow interrupt request, which is high while its overflow flag and its enable are both set.

Top module: `dual_timer8`

## Requirements
- R1: After reset the control/status byte reads 0x00, both counters read 0x00 and both compare registers read 0xFF.
- R2: The register addresses are: 0 control/status, 1 high counter, 2 low counter, 3 high compare, 4 low compare. Any other address reads 0x00. Read data is combinational from `addr_i`.
- R3: In each clock cycle where a half's tick is high, its counter increments by one. With that half's clear select at 0, the counter wraps from 0xFF to 0x00.
- R4: The overflow flag (bit 7 for the high half, bit 3 for the low half) sets after a ticked cycle in which the counter held 0xFF.
- R5: The compare flag (bit 6 for the high half, bit 2 for the low half) sets after a ticked cycle in which the counter equalled its compare register.
- R6: Writing 1 to bits 7, 6, 3 or 2 never sets the flag.
- R7: A flag clears only when 0 is written to it after a read returned it as 1, and that write uses up the read. A written 0 with no such prior read leaves the flag set.
- R8: A hardware set in the same cycle as a software clear leaves the flag at 1.
- R9: With the clear select set (bit 4 for the high half, bit 0 for the low half), a ticked cycle at a compare match loads the counter with 0x00 instead of incrementing it.
- R10: `irq_h_o` equals bit 7 AND bit 5, and `irq_l_o` equals bit 3 AND bit 1.
- R11: A bus write to a counter overrides counting in that cycle and raises no overflow or compare event.
- R12: Bits 5, 4, 1 and 0 are plain read/write bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe; arms flag clearing |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| tick_h_i | input | 1 | Count enable for the high counter |
| tick_l_i | input | 1 | Count enable for the low counter |
| irq_h_o | output | 1 | High overflow interrupt request |
| irq_l_o | output | 1 | Low overflow interrupt request |

## Verification
The hardest case to reach from the ports is a flag set and a flag clear landing in the same cycle. To set it up, the bench first reads the flag as 1 so the clear is armed. It then loads the counter with 0xFF and issues the clearing write in a cycle that also carries a tick, so the overflow event and the clear arrive together. The bench also writes 0 before any read, to confirm that an unarmed clear is ignored.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CSR_W   = 8;
  localparam int unsigned NHALF   = 2;  // index 1 = high, 0 = low
  localparam logic [ADDR_W-1:0] A_CSR   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_L = 3'd4;

  // per-half bit positions inside the status byte
  function automatic int unsigned ovf_bit(int unsigned h); return 3 + 4*h; endfunction
  function automatic int unsigned cmf_bit(int unsigned h); return 2 + 4*h; endfunction
  function automatic int unsigned ovie_bit(int unsigned h); return 1 + 4*h; endfunction
  function automatic int unsigned cclr_bit(int unsigned h); return 4*h; endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(int unsigned h);
    return (h == 1) ? A_CNT_H : A_CNT_L;
  endfunction
  function automatic logic [ADDR_W-1:0] cmp_addr(int unsigned h);
    return (h == 1) ? A_CMP_H : A_CMP_L;
  endfunction
endpackage

// File: rtl/dtmr_flag.sv
module dtmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // hardware set dominates an armed clear
      flag_q <= set_i | (flag_q & ~(clr_req_i & arm_q));
      arm_q  <= (rd_i & flag_q) | (arm_q & ~clr_req_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dtmr_half.sv
module dtmr_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_sel_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         match_evt_o,
  output logic         ovf_evt_o
);
  logic [W-1:0] cnt_q, cmp_q, cnt_d;
  logic         count_en;

  assign count_en    = tick_i & ~cnt_we_i;
  assign match_evt_o = count_en & (cnt_q == cmp_q);
  assign ovf_evt_o   = count_en & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we_i)                       cnt_d = wdata_i;
    else if (match_evt_o && clr_sel_i)  cnt_d = '0;
    else if (tick_i)                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_we_i) cmp_q <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
  import dtmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              tick_h_i,
  input  logic              tick_l_i,
  output logic              irq_h_o,
  output logic              irq_l_o
);
  logic                     csr_wr, csr_rd;
  logic [CSR_W-1:0]         csr;
  logic [NHALF-1:0]         tick;
  logic [NHALF-1:0][W-1:0]  cnt, cmp;
  logic [NHALF-1:0]         irq;
  logic [W-1:0]             cnt_h, cnt_l, cmp_h, cmp_l;

  assign csr_wr = wr_i & (addr_i == A_CSR);
  assign csr_rd = rd_i & (addr_i == A_CSR);
  assign tick   = {tick_h_i, tick_l_i};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic        match_evt, ovf_evt;
    logic [1:0]  ctrl_q;  // {ovie, cclr}

    dtmr_half #(.W(W)) u_half (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick[h]),
      .cnt_we_i   (wr_i & (addr_i == cnt_addr(h))),
      .cmp_we_i   (wr_i & (addr_i == cmp_addr(h))),
      .wdata_i    (wdata_i),
      .clr_sel_i  (ctrl_q[0]),
      .cnt_o      (cnt[h]),
      .cmp_o      (cmp[h]),
      .match_evt_o(match_evt),
      .ovf_evt_o  (ovf_evt)
    );

    dtmr_flag u_ovf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (ovf_evt),
      .rd_i     (csr_rd),
      .clr_req_i(csr_wr & ~wdata_i[ovf_bit(h)]),
      .flag_o   (csr[ovf_bit(h)])
    );

    dtmr_flag u_cmf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (match_evt),
      .rd_i     (csr_rd),
      .clr_req_i(csr_wr & ~wdata_i[cmf_bit(h)]),
      .flag_o   (csr[cmf_bit(h)])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ctrl_q <= '0;
      else if (csr_wr) ctrl_q <= {wdata_i[ovie_bit(h)], wdata_i[cclr_bit(h)]};
    end

    assign csr[ovie_bit(h)] = ctrl_q[1];
    assign csr[cclr_bit(h)] = ctrl_q[0];
    assign irq[h]           = csr[ovf_bit(h)] & ctrl_q[1];
  end

  assign cnt_h = cnt[1];
  assign cnt_l = cnt[0];
  assign cmp_h = cmp[1];
  assign cmp_l = cmp[0];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CSR:   rdata_o = W'(csr);
      A_CNT_H: rdata_o = cnt_h;
      A_CNT_L: rdata_o = cnt_l;
      A_CMP_H: rdata_o = cmp_h;
      A_CMP_L: rdata_o = cmp_l;
      default: rdata_o = '0;
    endcase
  end

  assign irq_h_o = irq[1];
  assign irq_l_o = irq[0];
endmodule

// File: rtl/dual_timer8_chk.sv
module dual_timer8_chk
  import dtmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [W-1:0]      wdata_i,
  input logic              tick_h_i,
  input logic              tick_l_i,
  input logic [CSR_W-1:0]  csr,
  input logic [W-1:0]      cnt_h,
  input logic [W-1:0]      cnt_l,
  input logic [W-1:0]      cmp_h
);
  logic wr_cnt_h, wr_cnt_l, wr_csr;
  assign wr_cnt_h = wr_i && addr_i == A_CNT_H;
  assign wr_cnt_l = wr_i && addr_i == A_CNT_L;
  assign wr_csr   = wr_i && addr_i == A_CSR;

  a_r3_low_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_l_i && !wr_cnt_l && !csr[0] |=> cnt_l == W'($past(cnt_l) + 1'b1));

  a_r4_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_h_i && !wr_cnt_h && cnt_h == '1 |=> csr[7]);

  a_r6_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csr[7]) |-> $past(tick_h_i && !wr_cnt_h && cnt_h == '1));

  a_r7_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr[3]) |-> $past(wr_csr && !wdata_i[3]));

  a_r9_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_h_i && !wr_cnt_h && csr[4] && cnt_h == cmp_h |=> cnt_h == '0);

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_l |=> cnt_l == $past(wdata_i));
endmodule

bind dual_timer8 dual_timer8_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .tick_h_i(tick_h_i),
  .tick_l_i(tick_l_i),
  .csr     (csr),
  .cnt_h   (cnt_h),
  .cnt_l   (cnt_l),
  .cmp_h   (cmp_h)
);

// File: tb/dual_timer8_test.sv
module dual_timer8_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick_h = 1'b0, tick_l = 1'b0;
  logic       irq_h, irq_l;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer8 uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_h_i(tick_h), .tick_l_i(tick_l),
    .irq_h_o(irq_h), .irq_l_o(irq_l)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%02h exp=0x%02h", req, got, exp);
    end
  endtask

  // one bus cycle; ticks held for that cycle; read data sampled before the edge
  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [7:0] d, input logic th, input logic tl,
                     output logic [7:0] q);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; tick_h = th; tick_l = tl;
    #1 q = rdata;
    @(posedge clk);
    #1;
    wr = 0; rd = 0; tick_h = 0; tick_l = 0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    cyc(1, 0, a, d, 0, 0, q);
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] q);
    cyc(0, 1, a, 8'h00, 0, 0, q);
  endtask

  task automatic ticks(input logic th, input logic tl, input int n);
    logic [7:0] q;
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd7, 8'h00, th, tl, q);
  endtask

  task automatic t_reset;
    logic [7:0] q;
    rreg(0, q); chk("R1 csr", q, 8'h00);
    rreg(1, q); chk("R1 cnt_h", q, 8'h00);
    rreg(2, q); chk("R1 cnt_l", q, 8'h00);
    rreg(3, q); chk("R1 cmp_h", q, 8'hFF);
    rreg(4, q); chk("R1 cmp_l", q, 8'hFF);
    rreg(7, q); chk("R2 unmapped", q, 8'h00);
  endtask

  task automatic t_count;
    logic [7:0] q;
    wreg(1, 8'h10);
    ticks(1, 0, 5);
    rreg(1, q); chk("R3 cnt_h count", q, 8'h15);
    rreg(2, q); chk("R3 cnt_l idle", q, 8'h00);
  endtask

  task automatic t_overflow;
    wreg(0, 8'h02);            // low overflow irq enable
    wreg(2, 8'hFE);
    ticks(0, 1, 2);            // FE->FF, FF->00 (also matches cmp 0xFF)
    chk("R10 irq_l", {7'd0, irq_l}, 8'h01);
    chk("R10 irq_h", {7'd0, irq_h}, 8'h00);
  endtask

  task automatic t_clear;
    logic [7:0] q;
    wreg(0, 8'h02);            // 0 to flags, no prior read
    rreg(0, q); chk("R7 unarmed zero ignored / R4 R5 low flags", q, 8'h0E);
    wreg(0, 8'h02);
    rreg(0, q); chk("R7 armed clear", q, 8'h02);
    chk("R10 irq_l low after clear", {7'd0, irq_l}, 8'h00);
    wreg(0, 8'hCC);
    rreg(0, q); chk("R6 write one no set", q, 8'h00);
  endtask

  task automatic t_clr_sel;
    logic [7:0] q;
    wreg(3, 8'h05);
    wreg(1, 8'h00);
    wreg(0, 8'h10);
    ticks(1, 0, 6);            // 1,2,3,4,5 then 0
    rreg(1, q); chk("R9 cleared on match", q, 8'h00);
    rreg(0, q); chk("R5 cmf_h set", q, 8'h50);
    ticks(1, 0, 2);
    rreg(1, q); chk("R9 resumes", q, 8'h02);
    wreg(0, 8'h00);            // armed by read above: clears bit 6
    rreg(0, q); chk("R7 cmf_h cleared", q, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] q;
    wreg(1, 8'hFF);
    ticks(1, 0, 1);
    rreg(0, q); chk("R4 ovf_h set", q, 8'h80);
    chk("R10 irq_h gated off", {7'd0, irq_h}, 8'h00);
    wreg(1, 8'hFF);
    cyc(1, 0, 0, 8'h00, 1, 0, q);  // armed clear with overflow in same cycle
    rreg(0, q); chk("R8 set wins", q, 8'h80);
    wreg(0, 8'h00);
    rreg(0, q); chk("R7 later clear", q, 8'h00);
  endtask

  task automatic t_wr_prio;
    logic [7:0] q;
    cyc(1, 0, 2, 8'h40, 0, 1, q);
    rreg(2, q); chk("R11 write over tick", q, 8'h40);
    wreg(2, 8'hFF);
    cyc(1, 0, 2, 8'hFF, 0, 1, q);  // counter at FF, tick, but written
    rreg(0, q); chk("R11 no event on write", q, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] q;
    wreg(0, 8'h33);
    rreg(0, q); chk("R12 ctrl bits", q, 8'h33);
    wreg(0, 8'h00);
    rreg(0, q); chk("R12 ctrl cleared", q, 8'h00);
    rreg(3, q); chk("R2 cmp_h readback", q, 8'h05);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_count();
    t_overflow();
    t_clear();
    t_clr_sel();
    t_set_wins();
    t_wr_prio();
    t_ctrl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog got=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule